// File: doc/BRIEF.md
# Sparse-Tap Pulse-Shaping FIR Filter

This block is a direct-form low-pass FIR filter that shapes a transmitter's symbol stream before modulation. Its coefficients are fixed when the design is built. They are signed 8-bit values taken from a raised-cosine response. The main lobe is kept and most side-lobe taps are zero. Each output is the sum over the filter length of coefficient times delayed input sample.

Every tap has a delay element. Only taps with a non-zero coefficient get a multiplier and a place in the adder tree. Arithmetic therefore grows with the number of surviving taps, not with the filter length. The default build has 33 taps, 11 of them non-zero.

The filter length is odd and is picked from 33, 49, 65, 81, 97, 113 or 129. The coefficient vector is a parameter, with tap k in bits [8k+7:8k]. Tap 0 multiplies the newest sample.

Top module: `sparse_fir_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every delayed sample is cleared to zero, `out_valid` goes to 0 and `out_data` goes to 0.
- R2: On an edge where `in_valid` is 1, the registered `out_data` equals the sum over k of c[k] times x[n-k]. Here x[n] is the sample on `in_data` at that edge, x[n-k] is the sample accepted k valid cycles earlier, samples older than the last reset count as zero, and c[k] is the signed byte at bits [8k+7:8k] of `COEF_VEC`.
- R3: `out_valid` is 1 exactly one clock after an edge with `in_valid` 1, and 0 one clock after an edge with `in_valid` 0.
- R4: An edge with `in_valid` 0 leaves the delay line unchanged and leaves `out_data` holding its last value, whatever `in_data` carries.
- R5: `out_data` is 8 + IN_W + ceil(log2(number of non-zero taps)) bits wide. It is exact for any input sequence, including full-scale inputs whose signs match the coefficients.
- R6: A single sample of value 1 followed by zeros produces, on successive valid outputs, c[0], c[1], ... c[NTAPS-1]. Zero taps yield exactly 0.
- R7: A reset applied in the middle of a stream discards all history. Outputs after it depend only on samples accepted after the reset, and `in_valid` during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_data` holds a new sample |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Strobe: `out_data` holds a new result |
| out_data | output | OUT_W | Signed full-precision filter output |

## Verification
The embedded assertions check on every cycle that the valid strobe follows the input strobe by exactly one clock. They also check that idle cycles freeze both the output and the far end of the delay line, that an accepted sample lands in the first delay stage, and that reset clears that stage.

The numeric behaviour can only be shown by the bench scenarios, which compare outputs with a convolution model. Those scenarios cover:
- the exact convolution value, including the placement of each zero tap, seen through the impulse response;
- full-scale inputs that probe the output width;
- a mid-stream reset that discards history.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

    localparam int COEF_W   = 8;
    localparam int MAX_TAPS = 129;
    localparam int VEC_W    = COEF_W * MAX_TAPS;

    // Number of non-zero coefficients among the first n taps.
    function automatic int count_nz(input logic [VEC_W-1:0] v, input int n);
        int cnt;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (v[k*COEF_W +: COEF_W] != '0) cnt++;
        end
        return cnt;
    endfunction

    // Tap index of the j-th non-zero coefficient (j counts from 0).
    function automatic int nz_index(input logic [VEC_W-1:0] v, input int n, input int j);
        int seen;
        int idx;
        seen = 0;
        idx  = 0;
        for (int k = 0; k < n; k++) begin
            if (v[k*COEF_W +: COEF_W] != '0) begin
                if (seen == j) idx = k;
                seen++;
            end
        end
        return idx;
    endfunction

    // Output width wide enough that the sum can never overflow.
    function automatic int acc_width(input int in_w, input int nz);
        return COEF_W + in_w + $clog2(nz < 1 ? 1 : nz);
    endfunction

    // Leaf count of the adder tree, rounded up to a power of two.
    function automatic int tree_leaves(input int nz);
        return 1 << $clog2(nz < 1 ? 1 : nz);
    endfunction

endpackage

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
    parameter int IN_W  = 12,
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W-1:0] taps [DEPTH]
);

    logic signed [IN_W-1:0] taps_d [DEPTH];
    logic signed [IN_W-1:0] taps_q [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) taps_d[k] = taps_q[k];
        if (shift_en) begin
            taps_d[0] = din;
            for (int k = 1; k < DEPTH; k++) taps_d[k] = taps_q[k-1];
        end
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) taps_d[k] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) taps_q[k] <= taps_d[k];
    end

    assign taps = taps_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (taps_q[0] == '0)); // R1

    AST_SAMPLE_ENTERS: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (taps_q[0] == $past(din))); // R2

    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps_q[DEPTH-1])); // R4

endmodule

// File: rtl/sfir_sparse_products.sv
module sfir_sparse_products
    import sfir_pkg::*;
#(
    parameter int                        NTAPS    = 33,
    parameter int                        IN_W     = 12,
    parameter logic [COEF_W*NTAPS-1:0]   COEF_VEC = '0,
    parameter int                        NZ       = 1
) (
    input  logic signed [IN_W-1:0]        window [NTAPS],
    output logic signed [COEF_W+IN_W-1:0] prods  [NZ]
);

    localparam int PW = COEF_W + IN_W;

    // One multiplier per surviving tap; zero taps produce no hardware.
    for (genvar j = 0; j < NZ; j++) begin : g_term
        localparam int K = nz_index(VEC_W'(COEF_VEC), NTAPS, j);
        localparam logic signed [COEF_W-1:0] C = COEF_VEC[K*COEF_W +: COEF_W];
        assign prods[j] = PW'(window[K]) * PW'(C);
    end

endmodule

// File: rtl/sfir_adder_tree.sv
module sfir_adder_tree
    import sfir_pkg::*;
#(
    parameter int NZ    = 1,
    parameter int PW    = 20,
    parameter int OUT_W = 24
) (
    input  logic signed [PW-1:0]    prods [NZ],
    output logic signed [OUT_W-1:0] sum
);

    localparam int LEAVES = tree_leaves(NZ);
    localparam int NODES  = 2 * LEAVES - 1;

    logic signed [OUT_W-1:0] node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NZ) begin : g_used
            assign node[LEAVES-1+i] = OUT_W'(prods[i]);
        end else begin : g_pad
            assign node[LEAVES-1+i] = '0;
        end
    end

    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
        assign node[i] = node[2*i+1] + node[2*i+2];
    end

    assign sum = node[0];

endmodule

// File: rtl/sparse_fir_top.sv
module sparse_fir_top
    import sfir_pkg::*;
#(
    parameter int                      NTAPS    = 33,
    parameter int                      IN_W     = 12,
    parameter logic [COEF_W*NTAPS-1:0] COEF_VEC = {
        80'h0,
        8'hE8, 8'hEB, 8'h00, 8'h25, 8'h50, 8'h72, 8'h7F,
        8'h72, 8'h50, 8'h25, 8'h00, 8'hEB, 8'hE8,
        80'h0},
    localparam int NZ    = count_nz(VEC_W'(COEF_VEC), NTAPS),
    localparam int OUT_W = acc_width(IN_W, NZ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    localparam int DEPTH = NTAPS - 1;
    localparam int PW    = COEF_W + IN_W;

    typedef struct packed {
        logic                    valid;
        logic signed [OUT_W-1:0] data;
    } res_t;

    logic signed [IN_W-1:0]  taps   [DEPTH];
    logic signed [IN_W-1:0]  window [NTAPS];
    logic signed [PW-1:0]    prods  [NZ];
    logic signed [OUT_W-1:0] sum;
    res_t                    res_d, res_q;

    sfir_delay_line #(.IN_W(IN_W), .DEPTH(DEPTH)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_data),
        .taps     (taps)
    );

    // Tap 0 is the incoming sample; the line supplies the older ones.
    assign window[0] = in_data;
    for (genvar k = 1; k < NTAPS; k++) begin : g_win
        assign window[k] = taps[k-1];
    end

    sfir_sparse_products #(
        .NTAPS(NTAPS), .IN_W(IN_W), .COEF_VEC(COEF_VEC), .NZ(NZ)
    ) u_prod (
        .window (window),
        .prods  (prods)
    );

    sfir_adder_tree #(.NZ(NZ), .PW(PW), .OUT_W(OUT_W)) u_tree (
        .prods (prods),
        .sum   (sum)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) res_d.data = sum;
        if (rst) res_d = '0;
    end

    always_ff @(posedge clk) begin
        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_data  = res_q.data;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R4

endmodule

// File: tb/tb_sparse_fir_top.sv
`timescale 1ns/1ps
module tb_sparse_fir_top;

    localparam int NTAPS = 33;
    localparam int IN_W  = 12;
    localparam int OUT_W = 24;
    localparam logic [8*NTAPS-1:0] TB_COEF = {
        80'h0,
        8'hE8, 8'hEB, 8'h00, 8'h25, 8'h50, 8'h72, 8'h7F,
        8'h72, 8'h50, 8'h25, 8'h00, 8'hEB, 8'hE8,
        80'h0};

    logic                    clk = 0;
    logic                    rst = 1;
    logic                    in_valid = 0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    longint hist [NTAPS];
    longint exp_data;

    always #2 clk = ~clk;

    sparse_fir_top #(.NTAPS(NTAPS), .IN_W(IN_W), .COEF_VEC(TB_COEF)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint coef(input int k);
        logic signed [7:0] c;
        c = TB_COEF[8*k +: 8];
        return longint'(c);
    endfunction

    function automatic longint conv();
        longint s;
        s = 0;
        for (int k = 0; k < NTAPS; k++) s += coef(k) * hist[k];
        return s;
    endfunction

    task automatic chk(input string req, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
        exp_data = 0;
    endtask

    // Drive one cycle, then compare against the model after the edge.
    task automatic step(input string req, input bit v, input longint d);
        @(negedge clk);
        in_valid = v;
        in_data  = IN_W'(d);
        @(posedge clk);
        #1;
        if (v) begin
            for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0]  = d;
            exp_data = conv();
        end
        chk({req, " valid strobe (R3)"}, out_valid == v, longint'(out_valid), longint'(v));
        chk(req, longint'(out_data) == exp_data, longint'(out_data), exp_data);
    endtask

    task automatic do_reset(input int cycles, input bit v_during);
        @(negedge clk);
        rst      = 1;
        in_valid = v_during;
        in_data  = 12'sh3A5;
        repeat (cycles) @(posedge clk);
        #1;
        model_reset();
        chk("R1 out_valid after reset", out_valid == 1'b0, longint'(out_valid), 0);
        chk("R1 out_data after reset", out_data == '0, longint'(out_data), 0);
        @(negedge clk);
        rst      = 0;
        in_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();

        // R1: reset state
        do_reset(3, 1'b0);

        // R6: impulse response walks through every coefficient, zero taps included
        step("R6 impulse", 1'b1, 1);
        for (int k = 1; k < NTAPS + 2; k++) step("R6 impulse", 1'b1, 0);

        // R4: idle cycles with garbage data must not shift or change output
        step("R2 pre-idle", 1'b1, 100);
        step("R2 pre-idle", 1'b1, -57);
        for (int k = 0; k < 5; k++) step("R4 idle hold", 1'b0, $urandom_range(0, 4095) - 2048);
        step("R4 resume after idle", 1'b1, 33);
        step("R4 resume after idle", 1'b1, -1);

        // R5: full-scale input, all negative then signs matched to coefficients
        for (int k = 0; k < NTAPS + 2; k++) step("R5 full-scale negative", 1'b1, -2048);
        for (int n = 0; n < NTAPS; n++) begin
            for (int k = 0; k < NTAPS; k++)
                hist[k] = (coef(k) < 0) ? -2048 : 2047;
            // feed the pattern so that tap k holds the matching sign
            break;
        end
        model_reset();
        do_reset(1, 1'b0);
        for (int k = NTAPS - 1; k >= 0; k--)
            step("R5 worst-case magnitude", 1'b1, (coef(k) < 0) ? -2048 : 2047);
        for (int k = NTAPS - 1; k >= 0; k--)
            step("R5 worst-case negative", 1'b1, (coef(k) < 0) ? 2047 : -2048);

        // R2: random stream with random gaps
        for (int i = 0; i < 3000; i++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(v ? "R2 random stream" : "R4 random gap", v, longint'($urandom_range(0, 4095)) - 2048);
        end

        // R7: mid-stream reset with in_valid held high during reset
        for (int i = 0; i < 10; i++) step("R2 before reset", 1'b1, longint'($urandom_range(0, 4095)) - 2048);
        do_reset(2, 1'b1);
        for (int i = 0; i < NTAPS + 4; i++)
            step("R7 history discarded", 1'b1, longint'($urandom_range(0, 4095)) - 2048);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule